// File: doc/BRIEF.md
# Boot-Time Memory Staging Sequencer

This block takes over the system bus at power-up so a boot image can be placed in SRAM before the processor ever fetches an instruction. On a start pulse it pulls the processor's active-low reset and halt lines low together, which floats the processor's buses. At the same time it starts a processor clock at one of two rates. It then waits a fixed settling interval and copies the image into memory one byte at a time.

Each byte costs three strobed bus transfers. The first clocks the low address byte into an external latch. The second clocks the high address byte into a second latch. The third pulses the SRAM write strobe while the data byte sits on the bus. Every strobe is stretched over several system clocks so that a slow SRAM captures cleanly. Each strobe is framed by one clock of setup and one clock of hold on the data bus.

Bytes come from an indexed source: the block presents an index, and the source answers with an address, a data byte and a valid flag. After the final byte the block releases the data bus first, then lets the processor run, then raises a done flag.

Top module: `boot_stager`

## Requirements
- R1: After a synchronous reset, `cpu_rst_n` and `cpu_halt_n` are high, `rdy_hold` is low, `bus_oe` is low and `bus_out` is zero, both latch clocks are low, `sram_we_n` is high, `cpu_clk` is low and `done` is low.
- R2: A `start` pulse sampled while idle or done drives `cpu_rst_n` and `cpu_halt_n` low together on the next clock, with `done` low.
- R3: From that same clock, `cpu_clk` toggles with a period of 4 system clocks when `clk_sel` was 0 at start, or 2 system clocks when it was 1. It keeps running after release until reset.
- R4: `bus_oe` first rises exactly `SETTLE_CYC` clocks after `cpu_rst_n` falls, and no strobe is active before that point.
- R5: Each byte is written by three strobes in a fixed order: `lat_lo_clk`, then `lat_hi_clk`, then `sram_we_n`. Each strobe is active for exactly `STB_CYC` clocks (latch clocks high, write strobe low). Strobes never overlap, and they are only active while the bus is driven and the processor is held.
- R6: `bus_out` carries address bits 7:0 during the first strobe, address bits 15:8 during the second, and the data byte during the write. The value is driven one clock before the strobe and stays unchanged until one clock after it.
- R7: Bytes are taken in index order 0 to `NUM_BYTES`-1 on `src_idx`. While `src_valid` is low the block waits without strobing, and it captures `src_addr` and `src_data` on the clock where `src_valid` is high.
- R8: A memory modelled as latching on the rising edge of each latch clock and writing on the rising edge of `sram_we_n` ends up holding every source byte at its source address.
- R9: After the last write, `bus_oe` falls first. `cpu_rst_n` and `cpu_halt_n` then rise together exactly one clock later.
- R10: `done` rises exactly one clock after `cpu_rst_n` rises and stays high until the next `start` is accepted.
- R11: `rdy_hold` is high on every clock where the processor is held in reset.
- R12: A `start` pulse while staging is in progress has no effect: the processor stays held, the sequence continues, and all bytes are still written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock pulse that begins staging |
| clk_sel | input | 1 | Processor clock rate: 0 gives period 4, 1 gives period 2 |
| src_idx | output | IDX_W | Index of the byte requested from the source |
| src_addr | input | 2*DATA_W | Memory address of the requested byte |
| src_data | input | DATA_W | Value of the requested byte |
| src_valid | input | 1 | Source address and data are valid |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_halt_n | output | 1 | Processor halt, active low |
| cpu_clk | output | 1 | Generated processor clock |
| rdy_hold | output | 1 | Forces processor ready high while held |
| bus_out | output | DATA_W | Data bus value |
| bus_oe | output | 1 | Data bus drive enable |
| lat_lo_clk | output | 1 | Low address latch clock, active high |
| lat_hi_clk | output | 1 | High address latch clock, active high |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| done | output | 1 | Staging complete |

## Verification
Every result has a fixed due time counted in system clocks:
- hold lines fall on the first clock after `start` is sampled;
- the bus comes up exactly `SETTLE_CYC` clocks later;
- each strobe lasts exactly `STB_CYC` clocks;
- the processor is released one clock after the bus drops;
- `done` follows one clock after that.

The bench drives inputs 2 ns after the rising edge. A monitor samples at the falling edge and stamps each output transition with a falling-edge count, so each interval is compared with its exact expected value and never with a bound. The sweep covers both clock rates, with and without source stalls, restarts from the done state, and start pulses injected mid-run.

// File: rtl/boot_stage_pkg.sv
// Package: shared state and transfer encodings for the boot staging sequencer.
// Assumes: transfer order LO, HI, WR is the order the strobes are issued.
package boot_stage_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_REL_BUS,
        ST_REL_CPU,
        ST_DONE
    } stage_e;

    typedef enum logic [1:0] {
        XF_LO = 2'd0,
        XF_HI = 2'd1,
        XF_WR = 2'd2
    } xfer_e;

endpackage

// File: rtl/stage_clkgen.sv
// Module: stage_clkgen
// Divides the system clock into a square processor clock while run is high.
// The half period is FAST_HALF clocks when fast is set, otherwise SLOW_HALF.
// Assumes: run only falls through reset; fast may change while running.
module stage_clkgen #(
    parameter int SLOW_HALF = 2,
    parameter int FAST_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic cpu_clk
);
    localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF + 1) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             ck_q;

    // Select the half-period length for the requested rate.
    always_comb limit = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);

    // Count out each half period and flip the output at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            ck_q  <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            ck_q  <= ~ck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cpu_clk = ck_q;

    // R3: at the fast rate the output flips on every clock once running.
    p_clk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && fast && $past(fast) && $past(cnt_q) == '0)
        |-> (cpu_clk != $past(cpu_clk)));

endmodule

// File: rtl/stage_timer.sv
// Module: stage_timer
// Loadable down counter shared by the settling wait and the strobe width.
// Loading N-1 on entry to a state makes expired rise after N clocks.
// Assumes: load is asserted for one clock per timed interval.
module stage_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: an unloaded nonzero count falls by exactly one per clock.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/boot_stager.sv
// Module: boot_stager (top)
// Holds the processor in reset and halt, waits SETTLE_CYC clocks, then writes
// NUM_BYTES bytes to SRAM through two address latches and a write strobe, each
// strobe STB_CYC clocks wide and framed by one setup and one hold clock.
// It then drops the bus, releases the processor one clock later and flags done.
// Assumes: address is 2*DATA_W bits; the source answers src_idx with valid.
module boot_stager
    import boot_stage_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_BYTES  = 256,
    parameter int SETTLE_CYC = 160000,
    parameter int STB_CYC    = 2,
    parameter int SLOW_HALF  = 2,
    parameter int FAST_HALF  = 1,
    localparam int ADDR_W    = 2 * DATA_W,
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clk_sel,
    output logic [IDX_W-1:0]  src_idx,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              cpu_rst_n,
    output logic              cpu_halt_n,
    output logic              cpu_clk,
    output logic              rdy_hold,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              lat_lo_clk,
    output logic              lat_hi_clk,
    output logic              sram_we_n,
    output logic              done
);
    localparam int TMR_MAX = (SETTLE_CYC > STB_CYC) ? SETTLE_CYC : STB_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int NXFER   = 3;

    stage_e             state_q;
    xfer_e              xfer_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               run_q;
    logic               fast_q;
    logic               held;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_done;
    logic [NXFER-1:0]   stb;

    // Shared interval timer: settle wait on start, strobe width on setup.
    always_comb begin
        tmr_load = ((state_q == ST_IDLE || state_q == ST_DONE) && start)
                   || (state_q == ST_SETUP);
        tmr_val  = (state_q == ST_SETUP) ? TMR_W'(STB_CYC - 1)
                                         : TMR_W'(SETTLE_CYC - 1);
    end

    stage_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    stage_clkgen #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .fast    (fast_q),
        .cpu_clk (cpu_clk)
    );

    // Sequence controller: hold, settle, three transfers per byte, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            xfer_q  <= XF_LO;
            idx_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            run_q   <= 1'b0;
            fast_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q <= ST_SETTLE;
                        idx_q   <= '0;
                        run_q   <= 1'b1;
                        fast_q  <= clk_sel;
                    end
                end
                ST_SETTLE:  if (tmr_done) state_q <= ST_FETCH;
                ST_FETCH: begin
                    if (src_valid) begin
                        addr_q  <= src_addr;
                        data_q  <= src_data;
                        xfer_q  <= XF_LO;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP:   state_q <= ST_PULSE;
                ST_PULSE:   if (tmr_done) state_q <= ST_HOLD;
                ST_HOLD: begin
                    if (xfer_q != XF_WR) begin
                        xfer_q  <= xfer_e'(xfer_q + 2'd1);
                        state_q <= ST_SETUP;
                    end else if (idx_q == IDX_W'(NUM_BYTES - 1)) begin
                        state_q <= ST_REL_BUS;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                ST_REL_BUS: state_q <= ST_REL_CPU;
                ST_REL_CPU: state_q <= ST_DONE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode ownership phases from the state.
    always_comb begin
        held   = (state_q == ST_SETTLE) || (state_q == ST_FETCH) ||
                 (state_q == ST_SETUP)  || (state_q == ST_PULSE) ||
                 (state_q == ST_HOLD)   || (state_q == ST_REL_BUS);
        bus_oe = (state_q == ST_FETCH) || (state_q == ST_SETUP) ||
                 (state_q == ST_PULSE) || (state_q == ST_HOLD);
    end

    // One strobe term per transfer kind, active only in the pulse phase.
    for (genvar k = 0; k < NXFER; k++) begin : g_stb
        assign stb[k] = (state_q == ST_PULSE) && (xfer_q == xfer_e'(k));
    end

    // Pick the byte placed on the bus for the current transfer.
    always_comb begin
        unique case (xfer_q)
            XF_LO:   bus_out = addr_q[DATA_W-1:0];
            XF_HI:   bus_out = addr_q[ADDR_W-1:DATA_W];
            default: bus_out = data_q;
        endcase
        if (!bus_oe) bus_out = '0;
    end

    assign src_idx    = idx_q;
    assign cpu_rst_n  = ~held;
    assign cpu_halt_n = ~held;
    assign rdy_hold   = held;
    assign lat_lo_clk = stb[XF_LO];
    assign lat_hi_clk = stb[XF_HI];
    assign sram_we_n  = ~stb[XF_WR];
    assign done       = (state_q == ST_DONE);

    // Checker support: clocks spent with the processor held, saturating.
    localparam int HC_W = $clog2(SETTLE_CYC + 1);
    logic [HC_W-1:0] held_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_rst_n) held_cnt <= '0;
        else if (held_cnt != HC_W'(SETTLE_CYC)) held_cnt <= held_cnt + 1'b1;
    end

    // R4: the bus comes up exactly after the settling interval.
    p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (held_cnt == HC_W'(SETTLE_CYC)));

    // R5: a strobe only fires while the bus is driven and the processor held.
    p_strobe_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_lo_clk || lat_hi_clk || !sram_we_n) |-> (bus_oe && !cpu_halt_n));

    // R6: bus value is unchanged from setup through pulse and hold.
    p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE || state_q == ST_HOLD) |-> $stable(bus_out));

    // R9: the processor is only released after the bus was already dropped.
    p_release_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> (!$past(bus_oe) && !$past(cpu_halt_n)));

    // R10: done follows a clock in which the processor was already running.
    p_done_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cpu_rst_n) && cpu_rst_n));

    // R12: a start seen mid-staging leaves the processor held.
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bus_oe) |=> !cpu_rst_n);

endmodule

// File: tb/tb_boot_stager.sv
// Bench for boot_stager: sweeps clock rate, source stalls, restart from done
// and mid-run start pulses on a small configuration, modelling latches and SRAM.
module tb_boot_stager;
    localparam int NB  = 6;
    localparam int SET = 20;
    localparam int STB = 3;
    localparam int IW  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clk_sel = 1'b0;
    logic [IW-1:0] src_idx;
    logic [15:0] src_addr;
    logic [7:0]  src_data;
    logic        src_valid;
    logic        cpu_rst_n, cpu_halt_n, cpu_clk, rdy_hold;
    logic [7:0]  bus_out;
    logic        bus_oe, lat_lo_clk, lat_hi_clk, sram_we_n, done;

    int  seed = 1;
    bit  stall_en = 1'b0;
    bit  gate = 1'b0;
    int  run_no = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_addr(int i, int s);
        return 16'(i * 4951 + s * 257 + 254);
    endfunction
    function automatic logic [7:0] exp_data(int i, int s);
        return 8'(i * 37 + s * 11 + 5);
    endfunction

    assign src_addr  = exp_addr(int'(src_idx), seed);
    assign src_data  = exp_data(int'(src_idx), seed);
    assign src_valid = !stall_en || gate;

    boot_stager #(
        .DATA_W(8), .NUM_BYTES(NB), .SETTLE_CYC(SET), .STB_CYC(STB),
        .SLOW_HALF(2), .FAST_HALF(1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_sel(clk_sel),
        .src_idx(src_idx), .src_addr(src_addr), .src_data(src_data),
        .src_valid(src_valid), .cpu_rst_n(cpu_rst_n), .cpu_halt_n(cpu_halt_n),
        .cpu_clk(cpu_clk), .rdy_hold(rdy_hold), .bus_out(bus_out),
        .bus_oe(bus_oe), .lat_lo_clk(lat_lo_clk), .lat_hi_clk(lat_hi_clk),
        .sram_we_n(sram_we_n), .done(done)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Falling-edge monitor: memory model and event timestamps.
    int cyc = 0, seen_run = 0;
    logic [2:0] pstb = 3'b000;
    logic p_oe = 1'b0, p_rst = 1'b1, p_done = 1'b0, p_ck = 1'b0;
    logic [IW-1:0] p_idx = '0;
    logic [7:0] lat_lo = '0, lat_hi = '0;
    logic [7:0] bus_at [3];
    int width [3];
    logic [15:0] wa [NB+2];
    logic [7:0]  wd [NB+2];
    int nw, exp_kind, bad_order, bad_width, bus_bad, idx_bad, rdy_bad, rst_falls;
    int t_rst_fall, t_oe_rise, t_oe_fall, t_rst_rise, t_done_rise;
    int ck_last, bad_period, n_periods, exp_period;

    always @(negedge clk) begin
        logic [2:0] s;
        cyc++;
        gate = (cyc % 3 == 0);
        if (run_no != seen_run) begin
            seen_run = run_no;
            nw = 0; exp_kind = 0; bad_order = 0; bad_width = 0; bus_bad = 0;
            idx_bad = 0; rdy_bad = 0; rst_falls = 0; ck_last = -1;
            bad_period = 0; n_periods = 0;
            t_rst_fall = -1; t_oe_rise = -1; t_oe_fall = -1;
            t_rst_rise = -1; t_done_rise = -1;
        end
        s = {!sram_we_n, lat_hi_clk, lat_lo_clk};
        for (int k = 0; k < 3; k++) begin
            if (s[k] && !pstb[k]) begin
                logic [7:0] ev;
                if (k != exp_kind) bad_order++;
                bus_at[k] = bus_out;
                width[k] = 1;
                ev = (k == 0) ? exp_addr(nw, seed)[7:0] :
                     (k == 1) ? exp_addr(nw, seed)[15:8] : exp_data(nw, seed);
                check(bus_out == ev, "R6", $sformatf("bus byte, kind %0d", k),
                      int'(bus_out), int'(ev));
                if (k == 0) lat_lo = bus_out;
                if (k == 1) lat_hi = bus_out;
            end else if (s[k] && pstb[k]) begin
                width[k]++;
                if (bus_out != bus_at[k]) bus_bad++;
            end else if (!s[k] && pstb[k]) begin
                if (width[k] != STB) bad_width++;
                if (bus_out != bus_at[k] || !bus_oe) bus_bad++;
                if (k == 2 && nw < NB + 2) begin
                    wa[nw] = {lat_hi, lat_lo};
                    wd[nw] = bus_out;
                    nw++;
                end
                exp_kind = (k + 1) % 3;
            end
        end
        if ($countones(s) > 1) bad_order++;
        if (!cpu_rst_n && !rdy_hold) rdy_bad++;
        if (cpu_rst_n != cpu_halt_n) rdy_bad++;
        if (src_idx != p_idx && src_idx != p_idx + 1'b1 && src_idx != '0) idx_bad++;
        if (p_rst && !cpu_rst_n) begin t_rst_fall = cyc; rst_falls++; end
        if (!p_rst && cpu_rst_n) t_rst_rise = cyc;
        if (!p_oe && bus_oe) t_oe_rise = cyc;
        if (p_oe && !bus_oe) t_oe_fall = cyc;
        if (!p_done && done) t_done_rise = cyc;
        if (cpu_clk && !p_ck) begin
            if (ck_last >= 0) begin
                n_periods++;
                if (cyc - ck_last != exp_period) bad_period++;
            end
            ck_last = cyc;
        end
        pstb = s; p_oe = bus_oe; p_rst = cpu_rst_n; p_done = done;
        p_ck = cpu_clk; p_idx = src_idx;
    end

    task automatic apply_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: idle state after reset
        check(cpu_rst_n && cpu_halt_n, "R1", "cpu hold lines high", int'({cpu_rst_n, cpu_halt_n}), 3);
        check(!rdy_hold && !bus_oe && bus_out == 8'd0, "R1", "bus and ready released",
              int'({rdy_hold, bus_oe, bus_out}), 0);
        check(!lat_lo_clk && !lat_hi_clk && sram_we_n, "R1", "strobes idle",
              int'({lat_lo_clk, lat_hi_clk, sram_we_n}), 1);
        check(!cpu_clk && !done, "R1", "clock stopped and done low", int'({cpu_clk, done}), 0);
    endtask

    task automatic run_once(int s, bit sel, bit stall, bit poke, bit from_done);
        int waitc;
        bit poked;
        @(posedge clk); #2;
        seed = s; clk_sel = sel; stall_en = stall;
        exp_period = sel ? 2 : 4;
        run_no++;
        if (from_done) begin
            // R10: done is still high long after completion, before restart
            repeat (5) @(posedge clk);
            #2;
            check(done == 1'b1, "R10", "done held until next start", int'(done), 1);
        end
        @(posedge clk); #2;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        check(!cpu_rst_n && !cpu_halt_n, "R2", "hold lines low after start",
              int'({cpu_rst_n, cpu_halt_n}), 0);
        check(!done, "R2", "done cleared after start", int'(done), 0);
        check(rdy_hold, "R11", "ready forced once held", int'(rdy_hold), 1);
        waitc = 0; poked = 1'b0;
        while (!done && waitc < 5000) begin
            @(posedge clk); #2;
            start = 1'b0;
            waitc++;
            if (poke && !poked && bus_oe && src_idx == IW'(2)) begin
                start = 1'b1;
                poked = 1'b1;
            end
        end
        start = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(done, "R10", "done reached", int'(done), 1);
        check(t_oe_rise - t_rst_fall == SET, "R4", "settle clocks to bus drive",
              t_oe_rise - t_rst_fall, SET);
        check(bad_order == 0, "R5", "strobe order and overlap errors", bad_order, 0);
        check(bad_width == 0, "R5", "strobe width errors", bad_width, 0);
        check(bus_bad == 0, "R6", "bus changes around a strobe", bus_bad, 0);
        check(idx_bad == 0, "R7", "index sequence errors", idx_bad, 0);
        check(nw == NB, "R8", "bytes written", nw, NB);
        for (int i = 0; i < NB; i++) begin
            check(wa[i] == exp_addr(i, s), "R8", $sformatf("address of byte %0d", i),
                  int'(wa[i]), int'(exp_addr(i, s)));
            check(wd[i] == exp_data(i, s), "R8", $sformatf("data of byte %0d", i),
                  int'(wd[i]), int'(exp_data(i, s)));
        end
        check(t_rst_rise - t_oe_fall == 1, "R9", "bus drop to cpu release",
              t_rst_rise - t_oe_fall, 1);
        check(t_done_rise - t_rst_rise == 1, "R10", "cpu release to done",
              t_done_rise - t_rst_rise, 1);
        check(rdy_bad == 0, "R11", "ready or halt mismatch while held", rdy_bad, 0);
        check(bad_period == 0 && n_periods > 4, "R3", "cpu clock period errors",
              bad_period, 0);
        if (poke) check(rst_falls == 1 && poked, "R12", "hold entries with mid-run start",
                        rst_falls, 1);
    endtask

    initial begin
        apply_reset();
        run_once(1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_once(2, 1'b0, 1'b1, 1'b1, 1'b1);
        apply_reset();
        run_once(3, 1'b1, 1'b1, 1'b0, 1'b0);
        run_once(4, 1'b1, 1'b0, 1'b1, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule